// File: doc/BRIEF.md
# Dirty Line Write-Back Staging Buffer

This block sits between a data cache and the memory bus. When the cache evicts or cleans a dirty line, it hands the whole line over in a single handshake: eight words, the physical line address and two half-line dirty flags. The buffer stores the line, which frees the cache at once. It then writes the line out in the background as a burst of word beats on its memory port. Because the address it writes to is the physical address captured with the line, no translation takes place on the way out.

The buffer holds exactly one line. It refuses a second capture until the last beat of the stored line has been accepted by memory. It is separate from the main write buffer but drains together with it. When a drain request is raised, either by a software barrier or by a wait-for-interrupt request, new captures are held off. The drain-complete output rises once this buffer is empty and the main write buffer also reports empty. Only the dirty part of a line goes to memory: a single dirty half produces a four-beat burst, both halves produce an eight-beat burst, and a clean line produces no traffic at all.

Top module: `line_wb_buffer`

## Requirements
- R1: After reset, cap_ready is 1 (with drain_req low), mem_valid is 0, busy is 0 and drain_done is 0.
- R2: A capture occurs on a clock edge where cap_valid and cap_ready are both 1. If the line has any dirty half, busy is 1 from the next cycle on and cap_ready stays 0 until the line has been written out.
- R3: With cap_dirty = 2'b11, the line is written as 8 beats in ascending order. Beat k carries word k, which is cap_data bits [32k+31:32k], at byte address base + 4k. mem_first is 1 on beat 0 only and mem_last is 1 on beat 7 only.
- R4: With cap_dirty = 2'b01 (low half dirty), only words 0 to 3 are written, as 4 beats at base, base+4, base+8 and base+12.
- R5: With cap_dirty = 2'b10 (high half dirty), only words 4 to 7 are written, as 4 beats starting at base+16.
- R6: A capture with cap_dirty = 2'b00 is accepted but produces no memory beat, and busy stays 0.
- R7: While mem_valid is 1 and mem_ready is 0, mem_addr, mem_data, mem_first and mem_last hold their values and mem_valid stays 1.
- R8: In the cycle after the beat with mem_last is accepted, mem_valid is 0, busy is 0 and cap_ready is 1 (with drain_req low).
- R9: While drain_req is 1, cap_ready is 0 and no capture takes place.
- R10: drain_done is 1 exactly when drain_req is 1, busy is 0 and mbuf_empty is 1.
- R11: The low 5 bits of cap_addr are ignored. The base address is cap_addr with those bits cleared, and it is used without any change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_valid | input | 1 | Cache offers a line |
| cap_ready | output | 1 | Buffer can take a line |
| cap_addr | input | 32 | Physical line address |
| cap_data | input | 256 | Eight line words, word 0 in the low bits |
| cap_dirty | input | 2 | Dirty flag per half line, bit 0 for the low half |
| mem_valid | output | 1 | Write beat offered |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | 32 | Byte address of the beat |
| mem_data | output | 32 | Beat data word |
| mem_first | output | 1 | First beat of a burst |
| mem_last | output | 1 | Last beat of a burst |
| drain_req | input | 1 | Drain or wait-for-interrupt request |
| mbuf_empty | input | 1 | Main write buffer is empty |
| drain_done | output | 1 | Both buffers are empty under a drain request |
| busy | output | 1 | A line is held |

## Verification
A corrupt word index or a wrong burst span shows up at once as a wrong address or wrong data on the next accepted beat, or as a burst whose length or first and last marks differ from what the dirty flags call for. A full flag stuck high, or one that clears too early, appears within a cycle of the final beat: cap_ready fails to return, or it returns while beats are still owed. A fault in the drain logic shows in the same cycle as drain_done rising while a line is held or while the main buffer is not empty.

// File: rtl/wbb_pkg.sv
package wbb_pkg;

    typedef enum logic [1:0] {
        DIRTY_NONE = 2'b00,
        DIRTY_LO   = 2'b01,
        DIRTY_HI   = 2'b10,
        DIRTY_ALL  = 2'b11
    } dirty_e;

    // First word index written for a given dirty pattern
    function automatic int unsigned span_first(input logic [1:0] dirty, input int unsigned words);
        return (dirty == DIRTY_HI) ? words / 2 : 0;
    endfunction

    // Last word index written for a given dirty pattern
    function automatic int unsigned span_last(input logic [1:0] dirty, input int unsigned words);
        return (dirty == DIRTY_LO) ? words / 2 - 1 : words - 1;
    endfunction

endpackage

// File: rtl/wbb_line_store.sv
module wbb_line_store #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int WORDS = 8,
    parameter int IW    = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [AW-1:0]       ld_base,
    input  logic [WORDS*DW-1:0] ld_data,
    input  logic [IW-1:0]       ld_first,
    input  logic [IW-1:0]       ld_last,
    input  logic                clear,
    output logic                full,
    output logic [AW-1:0]       base,
    output logic [WORDS*DW-1:0] data,
    output logic [IW-1:0]       first_idx,
    output logic [IW-1:0]       last_idx
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full      <= 1'b0;
            base      <= '0;
            first_idx <= '0;
            last_idx  <= '0;
        end else if (load) begin
            full      <= 1'b1;
            base      <= ld_base;
            first_idx <= ld_first;
            last_idx  <= ld_last;
        end else if (clear) begin
            full      <= 1'b0;
        end
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                data[w*DW +: DW] <= '0;
            else if (load)
                data[w*DW +: DW] <= ld_data[w*DW +: DW];
        end
    end

    a_r2_no_load_when_full: assert property (@(posedge clk) disable iff (rst)
        full && !clear |-> !load);

endmodule

// File: rtl/wbb_burst_seq.sv
module wbb_burst_seq #(
    parameter int WORDS = 8,
    parameter int IW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [IW-1:0] ld_first,
    input  logic          full,
    input  logic [IW-1:0] first_idx,
    input  logic [IW-1:0] last_idx,
    input  logic          beat_ready,
    output logic [IW-1:0] idx,
    output logic          beat_valid,
    output logic          beat_first,
    output logic          beat_last,
    output logic          done
);

    logic fire;

    assign beat_valid = full;
    assign beat_first = full && (idx == first_idx);
    assign beat_last  = full && (idx == last_idx);
    assign fire       = beat_valid && beat_ready;
    assign done       = fire && beat_last;

    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (load)
            idx <= ld_first;
        else if (fire && !beat_last)
            idx <= idx + 1'b1;
    end

    a_r3_index_steps_up: assert property (@(posedge clk) disable iff (rst)
        fire && !beat_last |=> idx == $past(idx) + 1'b1);

    a_r8_done_empties: assert property (@(posedge clk) disable iff (rst)
        done |=> !beat_valid);

endmodule

// File: rtl/wbb_drain_ctl.sv
module wbb_drain_ctl (
    input  logic clk,
    input  logic rst,
    input  logic drain_req,
    input  logic mbuf_empty,
    input  logic line_held,
    output logic block_capture,
    output logic drain_done
);

    assign block_capture = drain_req;
    assign drain_done    = drain_req && !line_held && mbuf_empty;

    a_r10_done_needs_main_empty: assert property (@(posedge clk) disable iff (rst)
        drain_done |-> mbuf_empty && !line_held);

endmodule

// File: rtl/line_wb_buffer.sv
module line_wb_buffer #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int WORDS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cap_valid,
    output logic                cap_ready,
    input  logic [AW-1:0]       cap_addr,
    input  logic [WORDS*DW-1:0] cap_data,
    input  logic [1:0]          cap_dirty,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_data,
    output logic                mem_first,
    output logic                mem_last,
    input  logic                drain_req,
    input  logic                mbuf_empty,
    output logic                drain_done,
    output logic                busy
);
    import wbb_pkg::*;

    localparam int IW         = $clog2(WORDS);
    localparam int WORD_BYTES = DW / 8;
    localparam int BSH        = $clog2(WORD_BYTES);
    localparam int OFS_W      = $clog2(WORDS * WORD_BYTES);

    logic                cap_fire, load, done, full, block;
    logic [AW-1:0]       ld_base, base;
    logic [IW-1:0]       ld_first, ld_last, first_idx, last_idx, idx;
    logic [WORDS*DW-1:0] data;

    assign cap_ready = !full && !block;
    assign cap_fire  = cap_valid && cap_ready;
    assign load      = cap_fire && (dirty_e'(cap_dirty) != DIRTY_NONE);
    assign ld_base   = {cap_addr[AW-1:OFS_W], {OFS_W{1'b0}}};
    assign ld_first  = IW'(span_first(cap_dirty, WORDS));
    assign ld_last   = IW'(span_last(cap_dirty, WORDS));
    assign busy      = full;

    wbb_line_store #(.AW(AW), .DW(DW), .WORDS(WORDS), .IW(IW)) u_store (
        .clk(clk), .rst(rst), .load(load), .ld_base(ld_base), .ld_data(cap_data),
        .ld_first(ld_first), .ld_last(ld_last), .clear(done), .full(full),
        .base(base), .data(data), .first_idx(first_idx), .last_idx(last_idx)
    );

    wbb_burst_seq #(.WORDS(WORDS), .IW(IW)) u_seq (
        .clk(clk), .rst(rst), .load(load), .ld_first(ld_first), .full(full),
        .first_idx(first_idx), .last_idx(last_idx), .beat_ready(mem_ready),
        .idx(idx), .beat_valid(mem_valid), .beat_first(mem_first),
        .beat_last(mem_last), .done(done)
    );

    wbb_drain_ctl u_drain (
        .clk(clk), .rst(rst), .drain_req(drain_req), .mbuf_empty(mbuf_empty),
        .line_held(full), .block_capture(block), .drain_done(drain_done)
    );

    assign mem_addr = base + (AW'(idx) << BSH);
    assign mem_data = data[idx*DW +: DW];

    a_r7_hold_while_stalled: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data)
        && $stable(mem_first) && $stable(mem_last));

    a_r3_addr_ascends: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_ready && !mem_last |=> mem_addr == $past(mem_addr) + AW'(WORD_BYTES));

    a_r9_no_capture_in_drain: assert property (@(posedge clk) disable iff (rst)
        drain_req |-> !cap_ready);

    a_r6_clean_line_no_beat: assert property (@(posedge clk) disable iff (rst)
        cap_fire && cap_dirty == 2'b00 |=> !mem_valid);

    a_r11_base_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_first |-> mem_addr[OFS_W-1:BSH+IW-1] == '0 || mem_addr[OFS_W-1:0] == OFS_W'(WORDS*WORD_BYTES/2));

endmodule

// File: tb/line_wb_buffer_test.sv
module line_wb_buffer_test;

    logic         clk = 1'b0;
    logic         rst;
    logic         cap_valid, cap_ready;
    logic [31:0]  cap_addr;
    logic [255:0] cap_data;
    logic [1:0]   cap_dirty;
    logic         mem_valid, mem_ready;
    logic [31:0]  mem_addr, mem_data;
    logic         mem_first, mem_last;
    logic         drain_req, mbuf_empty, drain_done, busy;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    line_wb_buffer uut (
        .clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_ready(cap_ready),
        .cap_addr(cap_addr), .cap_data(cap_data), .cap_dirty(cap_dirty),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_first(mem_first), .mem_last(mem_last),
        .drain_req(drain_req), .mbuf_empty(mbuf_empty), .drain_done(drain_done),
        .busy(busy)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int first_of(input logic [1:0] d);
        return (d == 2'b10) ? 4 : 0;
    endfunction

    function automatic int last_of(input logic [1:0] d);
        return (d == 2'b01) ? 3 : 7;
    endfunction

    // Offer a line, then collect and check its burst. stall_pct: chance of mem_ready low.
    task automatic run_line(input logic [31:0] a, input logic [255:0] d, input logic [1:0] dirty,
                            input int stall_pct, input string req);
        logic [31:0] base = {a[31:5], 5'b0};
        int k, guard;
        bit stalled = 0;
        logic [31:0] sa, sd;
        while (!cap_ready) @(negedge clk);
        cap_addr = a; cap_data = d; cap_dirty = dirty; cap_valid = 1'b1;
        mem_ready = 1'b0;
        @(negedge clk);
        cap_valid = 1'b0;
        if (dirty == 2'b00) begin
            check(!busy && !mem_valid, "R6", {30'd0, busy, mem_valid}, 32'd0);
            check(cap_ready, "R6", {31'd0, cap_ready}, 32'd1);
            return;
        end
        check(busy && !cap_ready, "R2", {30'd0, busy, cap_ready}, 32'd2);
        k = first_of(dirty);
        guard = 0;
        while (k <= last_of(dirty) && guard < 500) begin
            guard++;
            if (stalled)
                check(mem_valid && mem_addr == sa && mem_data == sd, "R7", mem_addr, sa);
            mem_ready = ($urandom % 100) >= stall_pct;
            if (mem_valid && mem_ready) begin
                check(mem_addr == base + 32'(4 * k), req, mem_addr, base + 32'(4 * k));
                check(mem_data == d[32*k +: 32], req, mem_data, d[32*k +: 32]);
                check(mem_first == (k == first_of(dirty)) && mem_last == (k == last_of(dirty)),
                      req, {30'd0, mem_first, mem_last},
                      {30'd0, 1'(k == first_of(dirty)), 1'(k == last_of(dirty))});
                k++;
                stalled = 0;
            end else begin
                stalled = mem_valid;
                sa = mem_addr; sd = mem_data;
            end
            @(negedge clk);
        end
        mem_ready = 1'b0;
        check(!mem_valid && !busy, "R8", {30'd0, mem_valid, busy}, 32'd0);
        check(cap_ready == !drain_req, "R8", {31'd0, cap_ready}, {31'd0, !drain_req});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; cap_valid = 0; cap_addr = 0; cap_data = 0; cap_dirty = 0;
        mem_ready = 0; drain_req = 0; mbuf_empty = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(cap_ready && !mem_valid && !busy && !drain_done, "R1",
              {28'd0, cap_ready, mem_valid, busy, drain_done}, 32'h8);

        // Directed: each dirty pattern
        run_line(32'h1000_0040, {8{32'hA5A5_0000}} ^ 256'h7_6_5_4_3_2_1_0, 2'b11, 0, "R3");
        run_line(32'h2000_0080, {$urandom, $urandom, $urandom, $urandom,
                                  $urandom, $urandom, $urandom, $urandom}, 2'b01, 30, "R4");
        run_line(32'h3000_00C0, {$urandom, $urandom, $urandom, $urandom,
                                  $urandom, $urandom, $urandom, $urandom}, 2'b10, 30, "R5");
        run_line(32'h4000_0100, 256'hDEAD, 2'b00, 0, "R6");
        // R11: low address bits ignored
        run_line(32'h5000_015F, {$urandom, $urandom, $urandom, $urandom,
                                  $urandom, $urandom, $urandom, $urandom}, 2'b11, 50, "R11");

        // Drain: line held, main buffer empty
        cap_addr = 32'h6000_0000; cap_data = {8{32'h1234_5678}}; cap_dirty = 2'b11;
        cap_valid = 1'b1; mem_ready = 1'b0;
        @(negedge clk);
        cap_valid = 1'b0; drain_req = 1'b1; mbuf_empty = 1'b1;
        @(negedge clk);
        check(!drain_done, "R10", {31'd0, drain_done}, 32'd0);
        check(!cap_ready, "R9", {31'd0, cap_ready}, 32'd0);
        mem_ready = 1'b1;
        repeat (8) @(negedge clk);
        mem_ready = 1'b0;
        check(!busy && drain_done, "R10", {30'd0, busy, drain_done}, 32'd1);
        check(!cap_ready, "R9", {31'd0, cap_ready}, 32'd0);
        // R9: capture attempt under drain is ignored
        cap_valid = 1'b1; cap_dirty = 2'b11;
        @(negedge clk);
        cap_valid = 1'b0;
        @(negedge clk);
        check(!busy && !mem_valid, "R9", {30'd0, busy, mem_valid}, 32'd0);
        mbuf_empty = 1'b0;
        @(negedge clk);
        check(!drain_done, "R10", {31'd0, drain_done}, 32'd0);
        mbuf_empty = 1'b1; drain_req = 1'b0;
        @(negedge clk);
        check(cap_ready && !drain_done, "R10", {30'd0, cap_ready, drain_done}, 32'h2);

        // Random lines
        for (int n = 0; n < 60; n++) begin
            logic [1:0] dd = 2'($urandom);
            string tag = (dd == 2'b11) ? "R3" : (dd == 2'b01) ? "R4" : (dd == 2'b10) ? "R5" : "R6";
            run_line($urandom, {$urandom, $urandom, $urandom, $urandom,
                                $urandom, $urandom, $urandom, $urandom}, dd, 40, tag);
            repeat ($urandom % 3) @(negedge clk);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule